// File: doc/BRIEF.md
# I2C Interrupt Vector and Status Unit

This unit sits beside an I2C controller core and turns the core's event pulses into software-visible interrupt state. Seven one-cycle event pulses each set a sticky flag. A per-event enable mask selects which flags may interrupt. The unit presents a status word, a small numeric vector code that names one pending enabled event, and a registered interrupt request line.

Software services the unit by reading the vector register until it returns zero. Each read of an event code other than the two data codes retires that event. The vector then moves on to the next pending enabled event. The receive-ready flag is retired by reading the receive data register, and the transmit-ready flag by writing the transmit data register. Both of these arrive as side-band strobes from the data path. Status flags can also be cleared by writing ones to the status register.

The register interface is a simple single-cycle access port with no back-pressure: a read or write completes in the cycle it is presented. Read data is combinational from the current state. The protocol engine and the clock generation are not part of this block.

Top module: `i2c_evt_vector`

## Requirements
- R1: After reset, all seven event flags, the mask register, the vector code and the interrupt request are 0.
- R2: A pulse on event input bit i sets status bit i at the next clock edge. The bit layout is: 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed as slave.
- R3: The vector code is i+1 for the lowest i whose flag and mask bit are both set, and 0 when no enabled flag is pending. This gives codes 1 for arbitration lost through 7 for addressed as slave.
- R4: Register address 0 is the mask. Its bits 6..0 hold the enables in the R2 layout and read back as written; bits 15..7 read as 0.
- R5: A flag whose mask bit is clear stays set. Enabling it later makes it appear in the vector and the interrupt request.
- R6: The interrupt request at address-independent output `irq_o` equals, one clock later, the OR of all flags ANDed with their mask bits.
- R7: Writing address 1 (status) clears each flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged.
- R8: Reading address 2 (vector) returns the current code in bits 2..0. For codes 1, 2, 3, 6 and 7 the read clears that flag, so the next read returns the next pending enabled code.
- R9: A vector read that returns code 4 or 5 leaves that flag set.
- R10: The receive-data-read strobe clears the receive-ready flag, and the transmit-data-write strobe clears the transmit-ready flag.
- R11: Status bit 11 follows the receive-full input and bit 12 follows the bus-busy input live. Neither affects the vector or the interrupt request.
- R12: An event pulse arriving in the same cycle as any clear of the same flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_in | input | 7 | One-cycle event pulses, R2 bit layout |
| bus_busy_i | input | 1 | Live bus-busy indication |
| rx_full_i | input | 1 | Live receive-shift-full indication |
| reg_addr | input | 2 | Register select: 0 mask, 1 status, 2 vector |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational |
| rx_data_rd | input | 1 | Strobe: receive data register was read |
| tx_data_wr | input | 1 | Strobe: transmit data register was written |
| status_o | output | 16 | Status word |
| vec_code_o | output | 3 | Current vector code |
| irq_o | output | 1 | Registered interrupt request |

## Verification
An event pulse or a clear presented before clock edge k changes the status word at edge k. The vector code is combinational from those flags, so it also changes at edge k. The interrupt request is registered once more and changes at edge k+1. The bench drives every stimulus on the falling edge and samples status and vector at the next falling edge. It samples the interrupt request one further falling edge later. Register reads are sampled shortly after the falling edge in the cycle the read strobe is high, before the edge that applies the read's clear.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int NUM_EV  = 7;
  localparam int REG_W   = 16;
  localparam int EV_RRDY = 3;
  localparam int EV_XRDY = 4;
  localparam int ST_RXF  = 11;
  localparam int ST_BUSY = 12;

  typedef enum logic [1:0] {
    RA_MASK = 2'd0,
    RA_STAT = 2'd1,
    RA_VEC  = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)        flag_o[i] <= 1'b0;
      else if (set_i[i]) flag_o[i] <= 1'b1;
      else if (clr_i[i]) flag_o[i] <= 1'b0;
    end

    // R2: an event pulse sets its flag on the next edge
    a_r2_set_next: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flag_o[i]);
    // R12: set and clear together leave the flag set
    a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i[i] && clr_i[i]) |=> flag_o[i]);
    // R5: without a clear a set flag persists
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o[i] && !clr_i[i]) |=> flag_o[i]);
  end
endmodule

// File: rtl/vec_prio_enc.sv
module vec_prio_enc #(
  parameter int N  = 7,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  req_i,
  output logic [CW-1:0] code_o
);
  always_comb begin
    code_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) code_o = CW'(i + 1);
    end
  end
endmodule

// File: rtl/i2c_evt_vector.sv
module i2c_evt_vector
  import i2c_evt_pkg::*;
#(
  parameter int NUM_EVT = NUM_EV,
  parameter int DATA_W  = REG_W,
  localparam int CODE_W = $clog2(NUM_EVT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] ev_in,
  input  logic               bus_busy_i,
  input  logic               rx_full_i,
  input  logic [1:0]         reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               rx_data_rd,
  input  logic               tx_data_wr,
  output logic [DATA_W-1:0]  status_o,
  output logic [CODE_W-1:0]  vec_code_o,
  output logic               irq_o
);
  localparam logic [CODE_W-1:0] CODE_RRDY = CODE_W'(EV_RRDY + 1);
  localparam logic [CODE_W-1:0] CODE_XRDY = CODE_W'(EV_XRDY + 1);

  logic [NUM_EVT-1:0] mask_q, flags, pend, clr;
  logic               vec_rd, stat_wr, mask_wr, irq_q;
  logic               unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_EVT];
  assign vec_rd  = reg_rd && (reg_addr == RA_VEC);
  assign stat_wr = reg_wr && (reg_addr == RA_STAT);
  assign mask_wr = reg_wr && (reg_addr == RA_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= reg_wdata[NUM_EVT-1:0];
  end

  // clear sources per flag
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_clr
    logic by_vec, by_data;
    if (i == EV_RRDY) begin : g_rx
      assign by_vec  = 1'b0;
      assign by_data = rx_data_rd;
    end else if (i == EV_XRDY) begin : g_tx
      assign by_vec  = 1'b0;
      assign by_data = tx_data_wr;
    end else begin : g_ctl
      assign by_vec  = vec_rd && (vec_code_o == CODE_W'(i + 1));
      assign by_data = 1'b0;
    end
    assign clr[i] = (stat_wr && reg_wdata[i]) || by_vec || by_data;
  end

  evt_flag_bank #(.N(NUM_EVT)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (ev_in),
    .clr_i (clr),
    .flag_o(flags)
  );

  assign pend = flags & mask_q;

  vec_prio_enc #(.N(NUM_EVT), .CW(CODE_W)) u_enc (
    .req_i (pend),
    .code_o(vec_code_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |pend;
  end
  assign irq_o = irq_q;

  always_comb begin
    status_o = '0;
    status_o[NUM_EVT-1:0] = flags;
    status_o[ST_RXF]  = rx_full_i;
    status_o[ST_BUSY] = bus_busy_i;
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_MASK: reg_rdata[NUM_EVT-1:0] = mask_q;
      RA_STAT: reg_rdata = status_o;
      RA_VEC:  reg_rdata[CODE_W-1:0] = vec_code_o;
      default: reg_rdata = '0;
    endcase
  end

  // R3: code is zero exactly when nothing enabled is pending
  a_r3_vec_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_code_o == '0) == (pend == '0));
  // R6: a rising request must stem from a pending enabled flag
  a_r6_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|pend));
  // R8: a retiring vector read removes exactly one flag
  a_r8_vec_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && vec_code_o != '0 && vec_code_o != CODE_RRDY &&
     vec_code_o != CODE_XRDY && !reg_wr && !rx_data_rd && !tx_data_wr &&
     ev_in == '0)
    |=> $countones(flags) == $past($countones(flags)) - 1);
  // R9: reading a data code leaves all flags in place
  a_r9_vec_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && (vec_code_o == CODE_RRDY || vec_code_o == CODE_XRDY) &&
     !reg_wr && !rx_data_rd && !tx_data_wr)
    |=> flags == ($past(flags) | $past(ev_in)));
endmodule

// File: tb/sim_i2c_evt_vector.sv
module sim_i2c_evt_vector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  ev_in = '0;
  logic        bus_busy_i = 1'b0, rx_full_i = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        rx_data_rd = 1'b0, tx_data_wr = 1'b0;
  logic [15:0] status_o;
  logic [2:0]  vec_code_o;
  logic        irq_o;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [6:0] fm, mm;

  always #5 clk = ~clk;

  i2c_evt_vector u0 (.*);

  function automatic logic [2:0] exp_vec(input logic [6:0] p);
    logic [2:0] c = 3'd0;
    for (int i = 6; i >= 0; i--) if (p[i]) c = 3'(i + 1);
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic pulse(input logic [6:0] p);
    ev_in = p; cyc(); ev_in = '0; fm |= p;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1; cyc(); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata; cyc(); reg_rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    fm = '0; mm = '0;
    // R1 reset state
    chk("R1 status", status_o, 16'h0);
    chk("R1 vector", vec_code_o, 3'd0);
    chk("R1 irq", irq_o, 1'b0);
    rd(2'd0, d); chk("R1 mask", d, 16'h0);

    // R4 mask readback, upper bits zero
    wr(2'd0, 16'hffff); rd(2'd0, d); chk("R4 mask rb", d, 16'h007f);
    wr(2'd0, 16'h0000); rd(2'd0, d); chk("R4 mask clr", d, 16'h0000);

    // R11 live bits do not interrupt
    wr(2'd0, 16'h007f); mm = 7'h7f;
    bus_busy_i = 1'b1; rx_full_i = 1'b1; cyc(); #1;
    chk("R11 busy bit", status_o[12], 1'b1);
    chk("R11 rxfull bit", status_o[11], 1'b1);
    chk("R11 vector", vec_code_o, 3'd0);
    cyc(); chk("R11 irq", irq_o, 1'b0);
    rd(2'd1, d); chk("R11 status read", d, 16'h1800);
    bus_busy_i = 1'b0; rx_full_i = 1'b0;

    // R12 event during status clear of the same flag
    reg_addr = 2'd1; reg_wdata = 16'h0004; reg_wr = 1'b1; ev_in = 7'h04;
    cyc(); reg_wr = 1'b0; ev_in = '0;
    chk("R12 set wins w1c", status_o[2], 1'b1);
    // R12 event during the vector read that would retire it
    reg_addr = 2'd2; reg_rd = 1'b1; ev_in = 7'h04; #1;
    chk("R12 vec code", reg_rdata[2:0], 3'd3);
    cyc(); reg_rd = 1'b0; ev_in = '0;
    chk("R12 set wins vec", status_o[2], 1'b1);
    // R7 partial clear
    pulse(7'h7f); fm = 7'h7f;
    wr(2'd1, 16'h0015);
    chk("R7 partial w1c", status_o[6:0], 7'h6a);
    wr(2'd1, 16'h007f);
    chk("R7 full w1c", status_o[6:0], 7'h00);
    fm = '0;

    // sweep of event patterns and masks
    for (int p = 0; p < 128; p++) begin
      logic [6:0] m;
      logic [15:0] v;
      m = p[0] ? 7'h7f : 7'((p * 37 + 11) & 127);
      wr(2'd0, {9'd0, m}); mm = m;
      pulse(7'(p));
      chk("R2 flags", status_o[6:0], fm);
      chk("R3 vector", vec_code_o, exp_vec(fm & mm));
      cyc();
      chk("R6 irq", irq_o, |(fm & mm));
      for (int k = 0; k < 10; k++) begin
        rd(2'd2, v);
        chk("R8 vector read", v, {13'd0, exp_vec(fm & mm)});
        if (v[2:0] == 3'd0) break;
        if (v[2:0] == 3'd4) begin
          chk("R9 rx ready kept", status_o[3], 1'b1);
          rx_data_rd = 1'b1; cyc(); rx_data_rd = 1'b0; fm[3] = 1'b0;
          chk("R10 rx ready cleared", status_o[3], 1'b0);
        end else if (v[2:0] == 3'd5) begin
          chk("R9 tx ready kept", status_o[4], 1'b1);
          tx_data_wr = 1'b1; cyc(); tx_data_wr = 1'b0; fm[4] = 1'b0;
          chk("R10 tx ready cleared", status_o[4], 1'b0);
        end else begin
          fm[v[2:0] - 3'd1] = 1'b0;
          chk("R8 retired", status_o[6:0], fm);
        end
      end
      cyc();
      chk("R6 irq drained", irq_o, 1'b0);
      // R5 masked flags survived and now raise the vector
      chk("R5 masked kept", status_o[6:0], 7'(p) & ~m);
      wr(2'd0, 16'h007f); mm = 7'h7f;
      chk("R5 enabled vector", vec_code_o, exp_vec(fm));
      cyc();
      chk("R5 enabled irq", irq_o, |fm);
      wr(2'd1, 16'h007f); fm = '0;
      chk("R7 sweep w1c", status_o[6:0], 7'h00);
    end
    finish_run();
  end
endmodule